// File: doc/BRIEF.md
# Multi-Source Lockstep Packet Receiver

This block is the receive half of a network-on-chip endpoint. It serves a destination core whose computation needs one data word from each of several source cores at once. Flits arrive from the router one at a time under a valid/ready handshake. An unpacking state machine reads a header flit that names the source and the payload length. It then pairs the 16-bit payload flits that follow into 32-bit words, each word carrying four 8-bit samples. Every finished word is pushed into a FIFO that belongs to its source.

The network delivers each source's packets in order. Word k in every FIFO therefore belongs to the same computation step. A joint reader pops all FIFOs together with one strobe, and only when three things hold: every FIFO has a word, the core can take one, and the core's result buffer has room. The head words of all FIFOs are presented side by side during that strobe. When the FIFO a word is headed for is full, the unpacker withholds ready and keeps the flit. Nothing is dropped.

Top module: `noc_sync_rx`

## Requirements
- R1: After a synchronous active-low reset, every source FIFO reports empty, the joint read strobe is low and the flit ready output is high.
- R2: A flit accepted while the unpacker is idle is a header. Bits [SID_W-1:0] hold the source number and bits [SID_W+LEN_W-1:SID_W] hold the count of 32-bit payload words that follow. SID_W is 2 for three sources and LEN_W is 4.
- R3: The first payload flit of each pair becomes bits [15:0] of the word and the second becomes bits [31:16]. The word enters its FIFO on the clock edge that accepts the second flit.
- R4: Each word goes only into the FIFO whose index equals the source number from its packet header.
- R5: While the second flit of a pair is offered and the target FIFO is full, ready is low and the unpacker holds its state. The flit is taken once space frees.
- R6: The joint read strobe is high exactly when no FIFO is empty, core_ready_i is high and out_full_i is low.
- R7: On each strobe, every FIFO's oldest word is shown in its slot of sync_data_o (source i at bits [32i+31:32i]) and removed. Each source keeps first-in first-out order.
- R8: Each FIFO stores up to DEPTH (8) words. The ninth word for a source whose FIFO is not drained is stalled.
- R9: A header with a payload count of zero carries no payload. The next accepted flit is again taken as a header.
- R10: The payload of a packet whose source number is not below NSRC is accepted and discarded, and no FIFO changes.
- R11: src_empty_o bit i is high exactly when FIFO i holds no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flit_i | input | FLIT_W | Flit from the router |
| flit_valid_i | input | 1 | Router offers flit_i |
| flit_ready_o | output | 1 | Unpacker takes flit_i this cycle when valid |
| core_ready_i | input | 1 | Core can consume a word set |
| out_full_i | input | 1 | Core result buffer is full |
| sync_valid_o | output | 1 | Joint read strobe; data set valid and popped |
| sync_data_o | output | NSRC*2*FLIT_W | Head words of all source FIFOs, source 0 in the low slot |
| src_empty_o | output | NSRC | Per-source FIFO empty flags |

## Verification
On every cycle, the embedded assertions check several conditions. No FIFO is written while full or read while empty. The strobe never fires while any source is empty. At most one FIFO is written per edge. A stalled second flit leaves the unpacker state and source unchanged. Other properties depend on sequences and can only be shown by the bench's scenarios, which compare against a queue model every cycle. These are the correct pairing of low and high halves, the routing by header source number, in-order lockstep pairing across sources, the ninth-word stall and its release by a read, zero-length headers, and discarding of out-of-range sources.

// File: rtl/nsr_pkg.sv
// Shared types for the multi-source lockstep receiver.
package nsr_pkg;
    // Unpacker states: waiting for header, expecting low half, expecting high half.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } unpack_st_e;
endpackage

// File: rtl/nsr_src_fifo.sv
// Per-source FIFO with show-ahead head word.
// Assumes: the writer never writes when full, and the reader never reads when empty.
module nsr_src_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign rd_data = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/nsr_unpacker.sv
// Header/payload unpacker: takes flits, joins pairs into words, routes by source.
// Assumes: the header carries source number in the low bits and word count above it.
module nsr_unpacker
    import nsr_pkg::*;
#(
    parameter int FLIT_W = 16,
    parameter int NSRC   = 2,
    parameter int LEN_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLIT_W-1:0]   flit_i,
    input  logic                flit_valid_i,
    output logic                flit_ready_o,
    input  logic [NSRC-1:0]     fifo_full_i,
    output logic [NSRC-1:0]     wr_en_o,
    output logic [2*FLIT_W-1:0] wr_data_o
);
    localparam int SID_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    unpack_st_e         st;
    logic [SID_W-1:0]   sid_q;
    logic [LEN_W-1:0]   left_q;
    logic [FLIT_W-1:0]  lo_q;
    logic               tgt_full;
    logic               accept;
    logic [LEN_W-1:0]   hdr_len;

    assign hdr_len = flit_i[SID_W+LEN_W-1:SID_W];

    // Fullness of the FIFO selected by the current packet (none if out of range).
    always_comb begin
        tgt_full = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (sid_q == SID_W'(i) && fifo_full_i[i]) tgt_full = 1'b1;
    end

    assign flit_ready_o = (st == ST_HI) ? !tgt_full : 1'b1;
    assign accept       = flit_valid_i && flit_ready_o;

    // One-hot write enable on acceptance of the high half.
    always_comb begin
        for (int i = 0; i < NSRC; i++)
            wr_en_o[i] = accept && (st == ST_HI) && (sid_q == SID_W'(i));
    end
    assign wr_data_o = {flit_i, lo_q};

    // Packet state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            sid_q  <= '0;
            left_q <= '0;
            lo_q   <= '0;
        end else if (accept) begin
            case (st)
                ST_IDLE: begin
                    sid_q  <= flit_i[SID_W-1:0];
                    left_q <= hdr_len;
                    st     <= (hdr_len == '0) ? ST_IDLE : ST_LO;
                end
                ST_LO: begin
                    lo_q <= flit_i;
                    st   <= ST_HI;
                end
                default: begin
                    left_q <= left_q - LEN_W'(1);
                    st     <= (left_q == LEN_W'(1)) ? ST_IDLE : ST_LO;
                end
            endcase
        end
    end

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HI && flit_valid_i && !flit_ready_o) |=> (st == ST_HI && $stable(sid_q)));
    assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_o));
endmodule

// File: rtl/nsr_joint_read.sv
// Lockstep read strobe for all source FIFOs.
// Assumes: empty flags come straight from the FIFOs.
module nsr_joint_read #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] empty_i,
    input  logic            core_ready_i,
    input  logic            out_full_i,
    output logic            rd_o
);
    // Pop all sources together only when each holds data and the core can proceed.
    always_comb rd_o = !(|empty_i) && core_ready_i && !out_full_i;
endmodule

// File: rtl/noc_sync_rx.sv
// Receive side of a NoC endpoint joining words from NSRC sources in lockstep.
// Assumes: in-order delivery per source; one flit per cycle at most.
module noc_sync_rx #(
    parameter int FLIT_W = 16,
    parameter int NSRC   = 2,
    parameter int DEPTH  = 8,
    parameter int LEN_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [FLIT_W-1:0]        flit_i,
    input  logic                     flit_valid_i,
    output logic                     flit_ready_o,
    input  logic                     core_ready_i,
    input  logic                     out_full_i,
    output logic                     sync_valid_o,
    output logic [NSRC*2*FLIT_W-1:0] sync_data_o,
    output logic [NSRC-1:0]          src_empty_o
);
    localparam int WORD_W = 2 * FLIT_W;

    logic [NSRC-1:0]   wr_en, full, empty;
    logic [WORD_W-1:0] wr_data;
    logic              rd;

    nsr_unpacker #(.FLIT_W(FLIT_W), .NSRC(NSRC), .LEN_W(LEN_W)) u_unpack (
        .clk          (clk),
        .rst_n        (rst_n),
        .flit_i       (flit_i),
        .flit_valid_i (flit_valid_i),
        .flit_ready_o (flit_ready_o),
        .fifo_full_i  (full),
        .wr_en_o      (wr_en),
        .wr_data_o    (wr_data)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        nsr_src_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[g]),
            .wr_data (wr_data),
            .rd_en   (rd),
            .rd_data (sync_data_o[g*WORD_W +: WORD_W]),
            .empty   (empty[g]),
            .full    (full[g])
        );
    end

    nsr_joint_read #(.NSRC(NSRC)) u_jread (
        .empty_i      (empty),
        .core_ready_i (core_ready_i),
        .out_full_i   (out_full_i),
        .rd_o         (rd)
    );

    assign sync_valid_o = rd;
    assign src_empty_o  = empty;

    assert_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid_o |-> (src_empty_o == '0));
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sync_valid_o && flit_ready_o));
endmodule

// File: tb/noc_sync_rx_bench.sv
module noc_sync_rx_bench;
    localparam int FLIT_W = 16;
    localparam int NSRC   = 3;
    localparam int DEPTH  = 8;
    localparam int LEN_W  = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [FLIT_W-1:0]        flit_i = '0;
    logic                     flit_valid_i = 1'b0;
    logic                     flit_ready_o;
    logic                     core_ready_i = 1'b0;
    logic                     out_full_i = 1'b0;
    logic                     sync_valid_o;
    logic [NSRC*32-1:0]       sync_data_o;
    logic [NSRC-1:0]          src_empty_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    noc_sync_rx #(.FLIT_W(FLIT_W), .NSRC(NSRC), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_noc_sync_rx (
        .clk(clk), .rst_n(rst_n), .flit_i(flit_i), .flit_valid_i(flit_valid_i),
        .flit_ready_o(flit_ready_o), .core_ready_i(core_ready_i), .out_full_i(out_full_i),
        .sync_valid_o(sync_valid_o), .sync_data_o(sync_data_o), .src_empty_o(src_empty_o)
    );

    // Behavioural reference: per-source queues and a packet phase.
    logic [31:0] mq [NSRC][$];
    int          m_phase = 0;   // 0 header, 1 low half, 2 high half
    int          m_sid = 0;
    int          m_left = 0;
    logic [15:0] m_lo = '0;
    bit          exp_rdy, exp_stb, last_acc, rand_mode = 0;

    function automatic bit model_ready();
        if (m_phase == 2 && m_sid < NSRC) return mq[m_sid].size() < DEPTH;
        return 1'b1;
    endfunction

    function automatic bit model_strobe();
        for (int i = 0; i < NSRC; i++) if (mq[i].size() == 0) return 1'b0;
        return core_ready_i && !out_full_i;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [NSRC-1:0] e_emp;
        exp_rdy = model_ready();
        exp_stb = model_strobe();
        for (int i = 0; i < NSRC; i++) e_emp[i] = (mq[i].size() == 0);
        chk(flit_ready_o === exp_rdy, "R5 ready", 64'(flit_ready_o), 64'(exp_rdy));
        chk(sync_valid_o === exp_stb, "R6 strobe", 64'(sync_valid_o), 64'(exp_stb));
        chk(src_empty_o === e_emp, "R11 empty", 64'(src_empty_o), 64'(e_emp));
        if (exp_stb)
            for (int i = 0; i < NSRC; i++)
                chk(sync_data_o[i*32 +: 32] === mq[i][0], "R2 R3 R4 R7 data",
                    64'(sync_data_o[i*32 +: 32]), 64'(mq[i][0]));
    endtask

    task automatic model_update();
        last_acc = 0;
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) mq[i].delete();
            m_phase = 0;
            return;
        end
        if (exp_stb) for (int i = 0; i < NSRC; i++) void'(mq[i].pop_front());
        if (flit_valid_i && exp_rdy) begin
            last_acc = 1;
            case (m_phase)
                0: begin
                    m_sid  = int'(flit_i[1:0]);
                    m_left = int'(flit_i[5:2]);
                    m_phase = (m_left == 0) ? 0 : 1;
                end
                1: begin m_lo = flit_i; m_phase = 2; end
                default: begin
                    if (m_sid < NSRC) mq[m_sid].push_back({flit_i, m_lo});
                    m_left--;
                    m_phase = (m_left == 0) ? 0 : 1;
                end
            endcase
        end
    endtask

    // One cycle: settle, compare, clock edge, update model.
    task automatic step();
        if (rand_mode) begin
            core_ready_i = ($urandom % 4) != 0;
            out_full_i   = ($urandom % 5) == 0;
        end
        #2;
        compare();
        @(posedge clk);
        model_update();
        #1;
    endtask

    task automatic send_flit(input logic [15:0] f);
        flit_i = f;
        flit_valid_i = 1'b1;
        do step(); while (!last_acc);
        flit_valid_i = 1'b0;
    endtask

    function automatic logic [15:0] hdr(input int sid, input int len);
        return 16'((len << 2) | sid);
    endfunction

    task automatic send_pkt(input int sid, input int len, input int seed);
        send_flit(hdr(sid, len));
        for (int k = 0; k < len; k++) begin
            send_flit(16'(seed * 16 + k * 2 + 16'h1000 * sid));
            send_flit(16'(16'hA000 + seed * 16 + k * 2 + 1));
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) begin @(posedge clk); model_update(); end
        #1;
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(src_empty_o === '1, "R1 empty after reset", 64'(src_empty_o), 64'h7);
        chk(sync_valid_o === 1'b0, "R1 strobe after reset", 64'(sync_valid_o), 0);
        chk(flit_ready_o === 1'b1, "R1 ready after reset", 64'(flit_ready_o), 1);
        @(posedge clk); model_update(); #1;

        // R6: no strobe while one source still empty
        send_pkt(0, 2, 1);
        send_pkt(1, 2, 2);
        repeat (2) step();
        chk(sync_valid_o === 1'b0, "R6 one source empty", 64'(sync_valid_o), 0);
        send_pkt(2, 2, 3);
        // R6: result buffer full blocks the read
        core_ready_i = 1'b1; out_full_i = 1'b1;
        repeat (2) step();
        out_full_i = 1'b0;
        repeat (3) step();

        // R9: zero-length header, next flit is a header again
        send_flit(hdr(1, 0));
        send_pkt(1, 1, 4);
        step();
        chk(src_empty_o === 3'b101, "R9 zero length then packet", 64'(src_empty_o), 64'h5);

        // R10: out-of-range source discarded
        send_pkt(3, 2, 5);
        step();
        chk(src_empty_o === 3'b101, "R10 discarded source", 64'(src_empty_o), 64'h5);
        send_pkt(0, 1, 6);
        send_pkt(2, 1, 7);
        repeat (3) step();

        // R8: fill source 0 beyond depth with the read blocked
        core_ready_i = 1'b0;
        send_pkt(1, 1, 8);
        send_pkt(2, 1, 9);
        send_flit(hdr(0, 9));
        for (int k = 0; k < 8; k++) begin
            send_flit(16'(16'h0200 + k));
            send_flit(16'(16'h0300 + k));
        end
        send_flit(16'h0299);
        flit_i = 16'h0399; flit_valid_i = 1'b1;
        repeat (3) begin
            step();
            chk(last_acc == 0 && flit_ready_o === 1'b0, "R8 ninth word stalled",
                64'(flit_ready_o), 0);
        end
        core_ready_i = 1'b1;   // R5: a read frees space, the held flit goes in
        do step(); while (!last_acc);
        flit_valid_i = 1'b0;
        send_pkt(1, 8, 10);
        send_pkt(2, 8, 11);
        repeat (4) step();

        // Random handshake traffic in rounds of equal length per source
        rand_mode = 1;
        for (int r = 0; r < 25; r++) begin
            int len = 1 + int'($urandom % 3);
            for (int s = 0; s < NSRC; s++) send_pkt(s, len, r + 12);
        end
        rand_mode = 0;
        core_ready_i = 1'b1; out_full_i = 1'b0;
        repeat (12) step();
        chk(src_empty_o === '1, "R7 all drained", 64'(src_empty_o), 64'h7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule